// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a watchdog. A counter advances on a slow clock-enable pulse and, unless software restarts it, reaches a timeout after a number of ticks picked by a 4-bit period field. One 8-bit control byte, written and read through a simple register port, holds a timeout flag, an interrupt enable, a reset enable, a change-enable indicator and the period field. The two enables together pick the mode. With the interrupt enable alone, a timeout raises the flag and asks for an interrupt. With the reset enable alone, a timeout asks for a system reset. With both set, the first timeout asks for an interrupt and a later one asks for a reset.

Byte layout (bit 7 down to bit 0): flag, interrupt enable, period bit 3, change enable, reset enable, period bits 2..0. Two safety fields are guarded. Software may clear the reset enable or change the period only in a short window. It opens that window by writing change enable and reset enable together.

The design has three state machines. A mode decoder maps the enables to `MODE_OFF`, `MODE_IRQ`, `MODE_RST` or `MODE_BOTH`. A reset latch moves from `WD_RUN` to `WD_FIRE` on a reset-causing timeout and stays there until the block reset. A guard moves from `PROT_LOCKED` to `PROT_OPEN` on an unlock write. It returns to `PROT_LOCKED` on the next write or when its window of `WIN` cycles runs out.

Top module: `wdt_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0 except bit 3, which equals `RE_INIT`. `irq_req` and `rst_req` are low.
- R2: In interrupt-only mode (bit 6 set, bit 3 clear), the flag (bit 7) sets at the clock edge that carries the 2^(N+BASE_EXP)-th tick. Ticks are counted from the edge that enabled the mode or restarted the counter.
- R3: `irq_req` is high exactly when the flag, the interrupt enable and `gie` are all high. It follows `gie` combinationally.
- R4: The flag clears on `irq_ack` or on a write with bit 7 at one. A write with bit 7 at zero leaves it unchanged. In interrupt-only mode, `irq_ack` leaves the interrupt enable set.
- R5: `kick` clears the counter, so the next timeout falls a full period later. It does not change the flag.
- R6: In reset-only mode (bit 3 set, bit 6 clear), a timeout raises `rst_req`. `rst_req` stays high until `rst_n` is asserted.
- R7: In combined mode, the first timeout sets the flag only. `irq_ack` clears both the flag and the interrupt enable. The following timeout then raises `rst_req`.
- R8: In combined mode, a timeout that arrives while the flag is still set raises `rst_req`.
- R9: The period value N is bits {5,2,1,0}. Values above `MAX_SEL` (default 9) act as `MAX_SEL`, while the stored field reads back as written.
- R10: While locked, a write may set the reset enable but cannot clear it or change the period. A write with bits 4 and 3 both set opens a window in which bit 4 reads 1. A write on any of the next `WIN` (4) edges applies all fields and closes the window. If no such write comes, bit 4 self-clears after those edges.
- R11: The counter advances only on edges where `tick_en` is high.
- R12: With both enables clear, the counter is held at zero and neither the flag nor `rst_req` can rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow-clock tick enable |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| kick | input | 1 | Watchdog restart |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Interrupt request |
| rst_req | output | 1 | System reset request |

## Verification
The hardest case to reach is the escalation in combined mode, where only the second timeout may reset and only if the first was acknowledged or left pending. The bench builds both histories. It restarts the counter on the enabling write, acknowledges exactly one cycle after the flag rises, and then counts edges to the reset. It also sends the unlock write and then waits exactly `WIN` and `WIN+1` edges, so that both sides of the window edge are seen. The bench runs with a small `BASE_EXP` so that even the saturated period completes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W     = 4;
    localparam int BIT_FLAG  = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_SELHI = 5;
    localparam int BIT_CE    = 4;
    localparam int BIT_RE    = 3;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IRQ  = 2'b01,
        MODE_RST  = 2'b10,
        MODE_BOTH = 2'b11
    } wd_mode_e;

    typedef enum logic {
        WD_RUN  = 1'b0,
        WD_FIRE = 1'b1
    } wd_state_e;

    typedef enum logic {
        PROT_LOCKED = 1'b0,
        PROT_OPEN   = 1'b1
    } prot_state_e;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int BASE_EXP = 11,
    parameter int MAX_SEL  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     tick,
    input  logic                     kick,
    input  logic [wdt_pkg::SEL_W-1:0] sel,
    output logic                     timeout
);
    localparam int CNT_W = BASE_EXP + MAX_SEL;

    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W-1:0]         limit;
    logic [CNT_W:0]           span;
    logic [wdt_pkg::SEL_W-1:0] eff;
    logic                     at_end;

    always_comb begin
        eff    = (sel > wdt_pkg::SEL_W'(MAX_SEL)) ? wdt_pkg::SEL_W'(MAX_SEL) : sel;
        span   = (CNT_W + 1)'(1) << (BASE_EXP + int'(eff));
        limit  = CNT_W'(span - 1'b1);
        at_end = (cnt_q >= limit);
    end

    assign timeout = run && !kick && tick && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (at_end) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (cnt_q == '0));
    assert_kick_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && run && !kick) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic unlock_req,
    output logic win_open
);
    import wdt_pkg::*;
    localparam int LEFT_W = $clog2(WIN + 1);

    prot_state_e       state_q, state_d;
    logic [LEFT_W-1:0] left_q, left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PROT_LOCKED;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            PROT_LOCKED: begin
                if (unlock_req) begin
                    state_d = PROT_OPEN;
                    left_d  = LEFT_W'(WIN);
                end
            end
            PROT_OPEN: begin
                if (wr_en || left_q == LEFT_W'(1)) begin
                    state_d = PROT_LOCKED;
                    left_d  = '0;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
        endcase
    end

    assign win_open = (state_q == PROT_OPEN);

    assert_window_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PROT_OPEN) |-> (left_q >= LEFT_W'(1) && left_q <= LEFT_W'(WIN)));
    assert_window_expire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PROT_OPEN && !wr_en && left_q == LEFT_W'(1)) |=> (state_q == PROT_LOCKED));
    assert_window_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PROT_OPEN && wr_en) |=> (state_q == PROT_LOCKED));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
    parameter int   BASE_EXP = 11,
    parameter int   MAX_SEL  = 9,
    parameter int   WIN      = 4,
    parameter logic RE_INIT  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       kick,
    input  logic       gie,
    input  logic       irq_ack,
    output logic       irq_req,
    output logic       rst_req
);
    import wdt_pkg::*;

    logic             flag_q, flag_d;
    logic             ie_q, ie_d;
    logic             re_q, re_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    wd_state_e        state_q, state_d;
    wd_mode_e         mode;
    logic             timeout;
    logic             win_open;
    logic             unlock_req;
    logic             run;

    assign mode       = wd_mode_e'({re_q, ie_q});
    assign run        = (ie_q || re_q) && (state_q == WD_RUN);
    assign unlock_req = wr_en && wr_data[BIT_CE] && wr_data[BIT_RE];

    wdt_timebase #(
        .BASE_EXP (BASE_EXP),
        .MAX_SEL  (MAX_SEL)
    ) i_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick_en),
        .kick    (kick),
        .sel     (sel_q),
        .timeout (timeout)
    );

    wdt_guard #(
        .WIN (WIN)
    ) i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .unlock_req (unlock_req),
        .win_open   (win_open)
    );

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            flag_q  <= 1'b0;
            ie_q    <= 1'b0;
            re_q    <= RE_INIT;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
            ie_q    <= ie_d;
            re_q    <= re_d;
            sel_q   <= sel_d;
        end
    end

    // Next-state logic: clears first, hardware events, then software writes
    always_comb begin
        state_d = state_q;
        flag_d  = flag_q;
        ie_d    = ie_q;
        re_d    = re_q;
        sel_d   = sel_q;

        if (irq_ack || (wr_en && wr_data[BIT_FLAG])) flag_d = 1'b0;

        unique case (mode)
            MODE_OFF: begin
            end
            MODE_IRQ: begin
                if (timeout) flag_d = 1'b1;
            end
            MODE_RST: begin
                if (timeout) state_d = WD_FIRE;
            end
            MODE_BOTH: begin
                if (irq_ack) ie_d = 1'b0;
                if (timeout) begin
                    if (flag_q) state_d = WD_FIRE;
                    flag_d = 1'b1;
                end
            end
        endcase

        if (wr_en) begin
            ie_d = wr_data[BIT_IE];
            if (win_open) begin
                re_d  = wr_data[BIT_RE];
                sel_d = {wr_data[BIT_SELHI], wr_data[2:0]};
            end else begin
                re_d  = re_q || wr_data[BIT_RE];
            end
        end
    end

    // Output process
    always_comb begin
        rst_req = (state_q == WD_FIRE);
        irq_req = flag_q && ie_q && gie;
        rd_data = {flag_q, ie_q, sel_q[3], win_open, re_q, sel_q[2:0]};
    end

    assert_flag_on_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && ie_q) |=> flag_q);
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !timeout) |=> !flag_q);
    assert_kick_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !irq_ack && !(wr_en && wr_data[BIT_FLAG])) |=> (flag_q == $past(flag_q)));
    assert_fire_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    assert_no_gie_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req);
    assert_re_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (re_q && !win_open) |=> re_q);
    assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(sel_q));
    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q && !re_q && state_q == WD_RUN) |=> !rst_req);
endmodule

// File: tb/test_wdt_ctrl.sv
module test_wdt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_ctrl #(.BASE_EXP(BASE), .MAX_SEL(9), .WIN(4), .RE_INIT(1'b0)) i_wdt_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .kick(kick), .gie(gie),
        .irq_ack(irq_ack), .irq_req(irq_req), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d, input logic with_kick);
        wr_en = 1'b1; wr_data = d; kick = with_kick;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; kick = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1; @(posedge clk); @(negedge clk); kick = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        apply_reset();
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq_req", irq_req, 0);
        check("R1 rst_req", rst_req, 0);
        idle(40);
        check("R12 no flag when off", rd_data[7], 0);
        check("R12 no reset when off", rst_req, 0);
    endtask

    task automatic t_irq_mode();
        gie = 1'b0;
        do_write(8'h40, 1'b1);
        idle(15);
        check("R2 flag before period", rd_data[7], 0);
        idle(1);
        check("R2 flag at period", rd_data, 8'hC0);
        check("R3 irq masked by gie", irq_req, 0);
        gie = 1'b1; #1;
        check("R3 irq with gie", irq_req, 1);
        @(negedge clk);
        do_write(8'h40, 1'b0);
        check("R4 write zero keeps flag", rd_data[7], 1);
        do_write(8'hC0, 1'b1);
        check("R4 write one clears flag", rd_data[7], 0);
        check("R3 irq drops", irq_req, 0);
        idle(16);
        check("R2 second flag", rd_data[7], 1);
        pulse_ack();
        check("R4 ack clears flag keeps IE", rd_data, 8'h40);
    endtask

    task automatic t_kick();
        do_write(8'hC0, 1'b1);
        idle(10);
        pulse_kick();
        idle(15);
        check("R5 restart delays timeout", rd_data[7], 0);
        idle(1);
        check("R5 timeout after restart", rd_data[7], 1);
        pulse_kick();
        check("R5 kick keeps flag", rd_data[7], 1);
    endtask

    task automatic t_tick_gate();
        do_write(8'hC0, 1'b1);
        tick_en = 1'b0;
        idle(50);
        check("R11 no count without tick", rd_data[7], 0);
        tick_en = 1'b1;
        idle(16);
        check("R11 count with tick", rd_data[7], 1);
    endtask

    task automatic t_prescale();
        do_write(8'h18, 1'b0);
        do_write(8'hC2, 1'b1);
        check("R10 window write applied", rd_data, 8'h42);
        idle(63);
        check("R9 N=2 before", rd_data[7], 0);
        idle(1);
        check("R9 N=2 at period", rd_data[7], 1);
        do_write(8'h18, 1'b0);
        do_write(8'hE4, 1'b1);
        check("R9 N=12 readback", rd_data, 8'h64);
        idle(8191);
        check("R9 N=12 saturated before", rd_data[7], 0);
        idle(1);
        check("R9 N=12 saturated at period", rd_data[7], 1);
    endtask

    task automatic t_protect();
        do_write(8'hC8, 1'b1);
        check("R10 set RE while locked", rd_data, 8'h6C);
        do_write(8'h40, 1'b0);
        check("R10 locked clear ignored", rd_data, 8'h6C);
        do_write(8'h58, 1'b0);
        check("R10 window visible", rd_data, 8'h7C);
        idle(4);
        check("R10 window self clears", rd_data, 8'h6C);
        do_write(8'h40, 1'b0);
        check("R10 late write ignored", rd_data, 8'h6C);
        do_write(8'h58, 1'b0);
        idle(3);
        do_write(8'h40, 1'b1);
        check("R10 write on last window edge", rd_data, 8'h40);
    endtask

    task automatic t_reset_mode();
        do_write(8'h08, 1'b1);
        idle(15);
        check("R6 no reset before period", rst_req, 0);
        idle(1);
        check("R6 reset at period", rst_req, 1);
        idle(5);
        check("R6 reset held", rst_req, 1);
        apply_reset();
        check("R6 cleared by rst_n", rst_req, 0);
        check("R1 rd after reset", rd_data, 8'h00);
    endtask

    task automatic t_combined();
        gie = 1'b1;
        do_write(8'h48, 1'b1);
        idle(16);
        check("R7 first timeout flag", rd_data, 8'hC8);
        check("R7 first timeout irq", irq_req, 1);
        check("R7 first timeout no reset", rst_req, 0);
        pulse_ack();
        check("R7 ack clears flag and IE", rd_data, 8'h08);
        idle(14);
        check("R7 no reset early", rst_req, 0);
        idle(1);
        check("R7 second timeout resets", rst_req, 1);
        apply_reset();
    endtask

    task automatic t_combined_pending();
        do_write(8'h48, 1'b1);
        idle(16);
        check("R8 flag set", rd_data[7], 1);
        idle(15);
        check("R8 no reset early", rst_req, 0);
        idle(1);
        check("R8 pending flag escalates", rst_req, 1);
        apply_reset();
    endtask

    initial begin
        t_reset_state();
        t_irq_mode();
        t_kick();
        t_tick_gate();
        t_prescale();
        t_protect();
        t_reset_mode();
        t_combined();
        t_combined_pending();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule